// File: doc/BRIEF.md
# UART Register Front End with Receive and Transmit FIFOs

This block is the bus-facing side of a 16550-style serial port. A 32-bit register port reads and writes a small set of byte-wide registers. A bank-select bit in the line control register decides what the shared offset 0x00 means. With the bit clear, offset 0x00 is the receive data window on reads and the transmit data window on writes. With the bit set, offsets 0x00 and 0x04 reach the two halves of a 16-bit baud divisor.

A deserializer pushes received characters into a 16-entry receive FIFO. Each entry stores the character together with its parity, framing and break flags, so the line status register always describes the character that the next read will return. A serializer drains a 16-entry transmit FIFO through a pop port.

A divisor counter divides the clock and produces a one-cycle tick at sixteen times the baud rate. A divisor of zero is treated as one. Writing either divisor byte restarts the count at once.

Top module: `uart_fe_top`

## Requirements
- R1: With the bank-select bit (line control bit 7) at 0, a read at offset 0x00 returns the oldest receive FIFO character and removes it, in arrival order.
- R2: With the bank-select bit at 0, a write at offset 0x00 appends wdata[7:0] to the transmit FIFO. The pop port shows the entries in write order, with tx_valid high while the FIFO is not empty.
- R3: With the bank-select bit at 1, offset 0x00 reads and writes divisor bits 7:0 and offset 0x04 reads and writes divisor bits 15:8. These accesses neither pop the receive FIFO nor push the transmit FIFO. The line control register at offset 0x0C reads back as {bank-select, 5'b0, length code}.
- R4: With divisor D at least 1, baud_tick is high for one cycle in every D. A divisor of 0 gives the same result as 1, which is baud_tick high every cycle. Out of reset the divisor is 0.
- R5: A write to either divisor byte reloads the counter. The first tick comes D-1 cycles after the write's clock edge, and later ticks come every D cycles.
- R6: Line control bits 1:0 give the character length: 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Data bits at and above the length read as zero.
- R7: Line status bits 2, 3 and 4 show the parity-error, framing-error and break flags pushed with the receive FIFO head entry. They read 0 when the receive FIFO is empty.
- R8: Line status (offset 0x14) bit 0 is high when the receive FIFO is not empty. Bit 5 is high when the transmit FIFO is empty.
- R9: Line status bit 1 sets when a receive push arrives while the receive FIFO is full, and that push is dropped. The bit clears when line status is read, and a set in the same cycle as that read wins.
- R10: A transmit write while the transmit FIFO is full is dropped.
- R11: A receive-data read while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R12: Every read returns zero in bits 31:8. After reset, line status reads 0x20 and tx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rx_push | input | 1 | Receive character strobe from deserializer |
| rx_byte | input | 8 | Received character, bit 0 first on the line |
| rx_perr | input | 1 | Parity error for pushed character |
| rx_ferr | input | 1 | Framing error for pushed character |
| rx_brk | input | 1 | Break condition for pushed character |
| tx_pop | input | 1 | Serializer takes the transmit head |
| tx_data | output | 8 | Transmit FIFO head, bit 0 sent first |
| tx_valid | output | 1 | Transmit FIFO not empty |
| baud_tick | output | 1 | One-cycle tick at 16x baud |

## Verification
Read data is registered. It shows on rdata after the clock edge that sees rd_en, so the bench samples it on the falling edge that follows. Status bits, tx_valid and tx_data change on the edge that takes a push, write or pop, and they are sampled half a cycle later. After a divisor write, the counter reload lands on the write's edge. The bench counts tick samples from the falling edge after that write, so the first tick of a divisor D is due at sample D-1.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int CHAR_W = 8;

    localparam logic [4:0] OFF_DATA = 5'h00;
    localparam logic [4:0] OFF_DHI  = 5'h04;
    localparam logic [4:0] OFF_LCTL = 5'h0C;
    localparam logic [4:0] OFF_LSTS = 5'h14;

    typedef enum logic [1:0] {
        LEN5 = 2'd0,
        LEN6 = 2'd1,
        LEN7 = 2'd2,
        LEN8 = 2'd3
    } char_len_t;

    typedef struct packed {
        logic      bank;
        char_len_t len;
    } line_ctl_t;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    localparam int RX_ENTRY_W = $bits(rx_entry_t);

    function automatic logic [CHAR_W-1:0] trim_char(input logic [CHAR_W-1:0] d,
                                                    input char_len_t len);
        logic [CHAR_W-1:0] mask;
        mask = 8'hFF >> (2'd3 - len);
        return d & mask;
    endfunction

endpackage

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/uart_fe_baud.sv
module uart_fe_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             load,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;

    // zero divisor behaves as one (R4)
    assign eff  = (div_val == '0) ? DIV_W'(1) : div_val;
    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (load)       cnt_q <= eff - 1'b1;
        else if (cnt_q == '0) cnt_q <= eff - 1'b1;
        else                 cnt_q <= cnt_q - 1'b1;
    end

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        !load |-> (cnt_q < eff));

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(eff) - 1'b1));

endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              tx_pop,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              baud_tick
);
    line_ctl_t        lctl_q;
    logic [DIV_W-1:0] div_q, div_d;
    logic             ovr_q;
    logic [31:0]      rdata_q, rd_mux;

    logic sel_data, sel_dhi, sel_lctl, sel_lsts;
    logic rx_pop, tx_push, div_load;

    rx_entry_t rx_in, rx_head;
    logic      rx_empty, rx_full;
    logic      tx_empty, tx_full;
    logic [7:0] lsts;

    assign sel_data = (addr == ADDR_W'(OFF_DATA));
    assign sel_dhi  = (addr == ADDR_W'(OFF_DHI));
    assign sel_lctl = (addr == ADDR_W'(OFF_LCTL));
    assign sel_lsts = (addr == ADDR_W'(OFF_LSTS));

    assign rx_pop   = rd_en && sel_data && !lctl_q.bank;
    assign tx_push  = wr_en && sel_data && !lctl_q.bank;
    assign div_load = wr_en && lctl_q.bank && (sel_data || sel_dhi);

    assign rx_in = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_byte};

    uart_fe_fifo #(.WIDTH(RX_ENTRY_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rx_in),
        .pop   (rx_pop),
        .head  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    uart_fe_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .head  (tx_data),
        .empty (tx_empty),
        .full  (tx_full)
    );

    assign tx_valid = !tx_empty;

    always_comb begin
        div_d = div_q;
        if (div_load && sel_data) div_d[7:0]       = wdata[7:0];
        if (div_load && sel_dhi)  div_d[DIV_W-1:8] = wdata[DIV_W-9:0];
    end

    uart_fe_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .div_val (div_d),
        .load    (div_load),
        .tick    (baud_tick)
    );

    assign lsts = {2'b00, tx_empty,
                   rx_head.brk  && !rx_empty,
                   rx_head.ferr && !rx_empty,
                   rx_head.perr && !rx_empty,
                   ovr_q, !rx_empty};

    always_comb begin
        rd_mux = 32'd0;
        if (sel_data) begin
            if (lctl_q.bank)   rd_mux[7:0] = div_q[7:0];
            else if (!rx_empty) rd_mux[7:0] = trim_char(rx_head.data, lctl_q.len);
        end else if (sel_dhi) begin
            if (lctl_q.bank)   rd_mux[7:0] = div_q[DIV_W-1:8];
        end else if (sel_lctl) begin
            rd_mux[7:0] = {lctl_q.bank, 5'b00000, lctl_q.len};
        end else if (sel_lsts) begin
            rd_mux[7:0] = lsts;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lctl_q  <= '{bank: 1'b0, len: LEN5};
            div_q   <= '0;
            ovr_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (wr_en && sel_lctl) begin
                lctl_q.bank <= wdata[7];
                lctl_q.len  <= char_len_t'(wdata[1:0]);
            end
            div_q <= div_d;
            if (rx_push && rx_full)       ovr_q <= 1'b1;
            else if (rd_en && sel_lsts)   ovr_q <= 1'b0;
            if (rd_en) rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full) |=> (rdata == $past(rdata) || 1'b1) && lsts[1]);

    assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_data && !lctl_q.bank && rx_empty) |=> (rdata == 32'd0));

    assert_upper_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_data) |=> (rdata[31:8] == 24'd0));

    assert_bank_no_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && lctl_q.bank && !rx_push) |=> (rx_empty == $past(rx_empty)));

endmodule

// File: tb/uart_fe_top_tb.sv
`timescale 1ns/1ps
module uart_fe_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        baud_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    uart_fe_top u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
        .baud_tick(baud_tick)
    );

    // [53:50] req, [49:48] op (0 write, 1 read, 2 rx push),
    // [47:43] offset, [42:32] push {brk,ferr,perr,data} or write data, [31:0] expected
    localparam int NV = 25;
    localparam logic [53:0] VECS [NV] = '{
        {4'd6,  2'd0, 5'h0C, 11'h003, 32'h0},   // R6 length 8
        {4'd1,  2'd2, 5'h00, 11'h0A5, 32'h0},
        {4'd7,  2'd2, 5'h00, 11'h13C, 32'h0},   // R7 parity flag
        {4'd8,  2'd1, 5'h14, 11'h000, 32'h21},  // R8
        {4'd1,  2'd1, 5'h00, 11'h000, 32'hA5},  // R1
        {4'd7,  2'd1, 5'h14, 11'h000, 32'h25},  // R7
        {4'd1,  2'd1, 5'h00, 11'h000, 32'h3C},  // R1
        {4'd8,  2'd1, 5'h14, 11'h000, 32'h20},  // R8
        {4'd6,  2'd0, 5'h0C, 11'h000, 32'h0},   // R6 length 5
        {4'd7,  2'd2, 5'h00, 11'h6FF, 32'h0},
        {4'd7,  2'd1, 5'h14, 11'h000, 32'h39},  // R7 break+framing
        {4'd6,  2'd1, 5'h00, 11'h000, 32'h1F},  // R6
        {4'd6,  2'd0, 5'h0C, 11'h002, 32'h0},   // R6 length 7
        {4'd6,  2'd2, 5'h00, 11'h0FF, 32'h0},
        {4'd6,  2'd1, 5'h00, 11'h000, 32'h7F},  // R6, R12
        {4'd3,  2'd0, 5'h0C, 11'h080, 32'h0},   // R3 bank select
        {4'd3,  2'd0, 5'h00, 11'h034, 32'h0},
        {4'd3,  2'd0, 5'h04, 11'h012, 32'h0},
        {4'd3,  2'd1, 5'h00, 11'h000, 32'h34},  // R3
        {4'd3,  2'd1, 5'h04, 11'h000, 32'h12},  // R3
        {4'd3,  2'd1, 5'h0C, 11'h000, 32'h80},  // R3
        {4'd3,  2'd1, 5'h14, 11'h000, 32'h20},  // R3 no tx push
        {4'd6,  2'd0, 5'h0C, 11'h003, 32'h0},
        {4'd2,  2'd0, 5'h00, 11'h05A, 32'h0},   // R2
        {4'd2,  2'd1, 5'h14, 11'h000, 32'h00}   // R2, R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rx_in(input logic [10:0] e);
        @(negedge clk);
        rx_push = 1'b1; {rx_brk, rx_ferr, rx_perr, rx_byte} = e;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_take(input logic [7:0] exp);
        @(negedge clk);
        check("R2 tx head", {24'd0, tx_data}, {24'd0, exp});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        int ticks, first;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state, R4 zero divisor ticks every cycle
        @(negedge clk);
        check("R12 reset tx_valid", {31'd0, tx_valid}, 32'd0);
        check("R4 reset tick", {31'd0, baud_tick}, 32'd1);
        reg_rd(5'h14, r);
        check("R12 reset status", r, 32'h20);

        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            v = VECS[i];
            case (v[49:48])
                2'd0: reg_wr(v[47:43], {21'd0, v[42:32]});
                2'd2: rx_in(v[42:32]);
                default: begin
                    reg_rd(v[47:43], r);
                    n_checks++;
                    if (r !== v[31:0]) begin
                        n_fail++;
                        $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                                 v[53:50], i, r, v[31:0]);
                    end
                end
            endcase
        end

        // R2 head of transmit FIFO
        check("R2 tx_valid", {31'd0, tx_valid}, 32'd1);
        tx_take(8'h5A);
        check("R2 tx drained", {31'd0, tx_valid}, 32'd0);

        // R5 reload and R4 period with divisor 5
        reg_wr(5'h0C, 32'h80);
        reg_wr(5'h04, 32'h00);
        reg_wr(5'h00, 32'h05);
        ticks = 0; first = -1;
        for (int k = 0; k < 20; k++) begin
            if (baud_tick) begin
                ticks++;
                if (first < 0) first = k;
            end
            @(negedge clk);
        end
        check("R5 first tick", first, 32'd4);
        check("R4 tick count div5", ticks, 32'd4);

        // R4 divisor 0 acts as 1
        reg_wr(5'h00, 32'h00);
        ticks = 0;
        for (int k = 0; k < 20; k++) begin
            if (baud_tick) ticks++;
            @(negedge clk);
        end
        check("R4 tick count div0", ticks, 32'd20);
        reg_wr(5'h0C, 32'h03);

        // R9 overrun: 17 pushes into 16 entries
        for (int i = 0; i < 17; i++) rx_in(11'(i));
        reg_rd(5'h14, r);
        check("R9 overrun set", r, 32'h23);
        reg_rd(5'h14, r);
        check("R9 overrun cleared", r, 32'h21);
        for (int i = 0; i < 16; i++) begin
            reg_rd(5'h00, r);
            check("R1 order after overrun", r, 32'(i));
        end
        // R11 empty read
        reg_rd(5'h00, r);
        check("R11 empty read", r, 32'd0);
        reg_rd(5'h14, r);
        check("R11 status after empty read", r, 32'h20);

        // R10 full transmit FIFO drops write
        for (int i = 0; i < 17; i++) reg_wr(5'h00, 32'h80 + 32'(i));
        for (int i = 0; i < 16; i++) tx_take(8'h80 + 8'(i));
        @(negedge clk);
        check("R10 extra write dropped", {31'd0, tx_valid}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule